// File: doc/BRIEF.md
# Signed-Digit to Two's-Complement Converter with Digit-Parallel Recoding

This block converts an N-digit binary signed-digit number into two's complement and, from the same operand, sign-magnitude and ones'-complement forms. Every digit lies in {-1, 0, +1} and arrives as a pair of bits, a plus bit and a minus bit. The subtraction that forms the two's-complement value is the only step with a carry chain.

Alongside the subtraction, a prefix scan over the signed digits finds, for each position i, the sign of the partial number made of digits i down to 0. Position i gets a tag bit that is set when any digit at or below i is nonzero. That bit is the low bit of the position's prefix sign code. The tags are available as soon as the digits are, so the two's-complement result can be turned into sign-magnitude form one bit at a time. Each magnitude bit is either passed through or inverted, and no second carry chain is needed. The ones'-complement form then comes from inverting the magnitude bits of a negative sign-magnitude result.

All outputs are registered once and appear on the clock edge after the operand is presented. The result wraps modulo 2^N. The single two's-complement value that has no sign-magnitude equivalent, 1 followed by zeros, raises an overflow flag.

Top module: `sd_reverse_conv`

## Requirements
- R1: One clock edge after the operand is applied, `tc_o` equals (plus vector − minus vector) modulo 2^N.
- R2: The digit at position i is given by the pair (plus[i], minus[i]): 10 is +1, 01 is −1, and both 00 and 11 are 0. The illegal pair 11 therefore acts exactly like a zero digit in every output.
- R3: `tag_o[i]` is 1 when at least one digit at positions i..0 is nonzero, and 0 otherwise.
- R4: `psign_o[2i+1:2i]` is the sign of the partial number made of digits i..0. It is 00 for zero, 01 for positive and 11 for negative, which is the sign of the highest nonzero digit at or below i. The code 10 never appears.
- R5: For every position, `tag_o[i]` equals the OR of `tc_o[i:0]`.
- R6: When overflow is clear, `sm_o[N-1]` equals `tc_o[N-1]`. If that bit is 0, `sm_o` equals `tc_o`. If it is 1, `sm_o[N-2:0]` is the magnitude of the negative value. For example, with N = 6, a `tc_o` of 110011 gives tags 111111 and a `sm_o` of 101101.
- R7: `ovf_o` is 1 exactly when `tc_o` is 1 followed by N−1 zeros. `sm_o` and `oc_o` are unspecified in that case.
- R8: When overflow is clear, `oc_o` equals `sm_o` for a non-negative result. For a negative result, `oc_o` has sign bit 1 and holds `sm_o[N-2:0]` inverted.
- R9: While `rst_n` is low, every output is 0.
- R10: An all-zero operand gives zero two's-complement, tag, sign code, sign-magnitude and ones'-complement outputs, with overflow clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_pos_i | input | N | Plus bit of each signed digit |
| sd_neg_i | input | N | Minus bit of each signed digit |
| tc_o | output | N | Two's-complement result |
| tag_o | output | N | Per-position conversion tags |
| psign_o | output | 2N | Two-bit prefix sign code per position |
| sm_o | output | N | Sign-magnitude result |
| oc_o | output | N | Ones'-complement result |
| ovf_o | output | 1 | Result has no sign-magnitude form |

## Verification
At N = 6 the bench walks every one of the 4096 combinations of plus and minus vectors. The sweep covers all 729 legal digit strings and every string that contains the illegal pair. Legal strings whose value lies outside the N-bit range show whether the recoding follows the wrapped two's-complement value or the true digit value. Strings whose low digits cancel, such as +1 followed by −1, separate a zero prefix from a zero digit in the tag and sign-code logic. The all-zero operand, the operand that maps onto the overflow code, and the worked value 110011 are also checked on their own.

// File: rtl/sdrc_pkg.sv
package sdrc_pkg;

    // Two-bit sign code of a partial signed-digit number
    typedef enum logic [1:0] {
        PSGN_ZERO = 2'b00,
        PSGN_POS  = 2'b01,
        PSGN_NEG  = 2'b11
    } psign_e;

    // A digit is nonzero when exactly one of its two bits is set
    function automatic logic digit_nonzero(input logic plus_b, input logic minus_b);
        return plus_b ^ minus_b;
    endfunction

endpackage

// File: rtl/sdrc_sign_scan.sv
module sdrc_sign_scan
    import sdrc_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]   plus_i,
    input  logic [N-1:0]   minus_i,
    output logic [2*N-1:0] psign_o,
    output logic [N-1:0]   tag_o
);

    psign_e code [N];

    // Position 0 starts from a zero sign; each higher position keeps the
    // code below unless its own digit is nonzero.
    for (genvar i = 0; i < N; i++) begin : g_scan
        psign_e below;
        if (i == 0) begin : g_base
            assign below = PSGN_ZERO;
        end else begin : g_link
            assign below = code[i-1];
        end

        always_comb begin
            if (digit_nonzero(plus_i[i], minus_i[i])) begin
                code[i] = minus_i[i] ? PSGN_NEG : PSGN_POS;
            end else begin
                code[i] = below;
            end
        end

        assign psign_o[2*i +: 2] = code[i];
        assign tag_o[i]          = code[i][0];
    end

endmodule

// File: rtl/sdrc_subtract.sv
module sdrc_subtract #(
    parameter int N = 8
) (
    input  logic [N-1:0] plus_i,
    input  logic [N-1:0] minus_i,
    output logic [N-1:0] tc_o
);

    // The only carry-propagating step of the block
    always_comb begin
        tc_o = plus_i - minus_i;
    end

endmodule

// File: rtl/sdrc_recode.sv
module sdrc_recode #(
    parameter int N = 8
) (
    input  logic [N-1:0] tc_i,
    input  logic [N-1:0] tag_i,
    output logic [N-1:0] sm_o,
    output logic [N-1:0] oc_o,
    output logic         ovf_o
);

    localparam int MAG_W = N - 1;

    logic             neg;
    logic [MAG_W-1:0] flip;

    assign neg = tc_i[N-1];

    // Bit i of a negative value is inverted once any lower bit is set
    for (genvar i = 0; i < MAG_W; i++) begin : g_flip
        if (i == 0) begin : g_lsb
            assign flip[i] = 1'b0;
        end else begin : g_upper
            assign flip[i] = neg & tag_i[i-1];
        end
    end

    always_comb begin
        sm_o[N-1]       = tc_i[N-1];
        sm_o[MAG_W-1:0] = tc_i[MAG_W-1:0] ^ flip;
        oc_o[N-1]       = sm_o[N-1];
        oc_o[MAG_W-1:0] = neg ? ~sm_o[MAG_W-1:0] : sm_o[MAG_W-1:0];
        ovf_o           = neg & ~tag_i[N-2];
    end

endmodule

// File: rtl/sd_reverse_conv.sv
module sd_reverse_conv #(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   sd_pos_i,
    input  logic [N-1:0]   sd_neg_i,
    output logic [N-1:0]   tc_o,
    output logic [N-1:0]   tag_o,
    output logic [2*N-1:0] psign_o,
    output logic [N-1:0]   sm_o,
    output logic [N-1:0]   oc_o,
    output logic           ovf_o
);

    localparam int CODE_W = 2 * N;

    logic [N-1:0]      tc_w;
    logic [N-1:0]      tag_w;
    logic [CODE_W-1:0] psign_w;
    logic [N-1:0]      sm_w;
    logic [N-1:0]      oc_w;
    logic              ovf_w;

    sdrc_sign_scan #(.N(N)) u_scan (
        .plus_i  (sd_pos_i),
        .minus_i (sd_neg_i),
        .psign_o (psign_w),
        .tag_o   (tag_w)
    );

    sdrc_subtract #(.N(N)) u_sub (
        .plus_i  (sd_pos_i),
        .minus_i (sd_neg_i),
        .tc_o    (tc_w)
    );

    sdrc_recode #(.N(N)) u_recode (
        .tc_i  (tc_w),
        .tag_i (tag_w),
        .sm_o  (sm_w),
        .oc_o  (oc_w),
        .ovf_o (ovf_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc_o    <= '0;
            tag_o   <= '0;
            psign_o <= '0;
            sm_o    <= '0;
            oc_o    <= '0;
            ovf_o   <= 1'b0;
        end else begin
            tc_o    <= tc_w;
            tag_o   <= tag_w;
            psign_o <= psign_w;
            sm_o    <= sm_w;
            oc_o    <= oc_w;
            ovf_o   <= ovf_w;
        end
    end

endmodule

// File: rtl/sd_reverse_conv_chk.sv
module sd_reverse_conv_chk #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   sd_pos_i,
    input logic [N-1:0]   sd_neg_i,
    input logic [N-1:0]   tc_o,
    input logic [N-1:0]   tag_o,
    input logic [2*N-1:0] psign_o,
    input logic [N-1:0]   sm_o,
    input logic [N-1:0]   oc_o,
    input logic           ovf_o
);

    localparam logic [N-1:0] MIN_CODE = {1'b1, {(N-1){1'b0}}};

    function automatic logic [N-1:0] prefix_or(input logic [N-1:0] v);
        logic [N-1:0] r;
        logic         run;
        run = 1'b0;
        for (int i = 0; i < N; i++) begin
            run  = run | v[i];
            r[i] = run;
        end
        return r;
    endfunction

    function automatic logic has_code10(input logic [2*N-1:0] c);
        logic bad;
        bad = 1'b0;
        for (int i = 0; i < N; i++) begin
            bad = bad | (c[2*i+1] & ~c[2*i]);
        end
        return bad;
    endfunction

    AST_TC_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> tc_o == ($past(sd_pos_i) - $past(sd_neg_i)));                // R1
    AST_TAG_FROM_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> tag_o == prefix_or($past(sd_pos_i) ^ $past(sd_neg_i)));      // R3
    AST_PSIGN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        !has_code10(psign_o));                                               // R4
    AST_TAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        tag_o == prefix_or(tc_o));                                           // R5
    AST_SM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_o |-> sm_o[N-1] == tc_o[N-1]);                                  // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o == (tc_o == MIN_CODE));                                        // R7
    AST_OC_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_o && !sm_o[N-1]) |-> oc_o == sm_o);                            // R8
    AST_ZERO_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_pos_i == '0 && sd_neg_i == '0) |=> (sm_o == '0 && !ovf_o));      // R10

endmodule

bind sd_reverse_conv sd_reverse_conv_chk #(.N(N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sd_pos_i (sd_pos_i),
    .sd_neg_i (sd_neg_i),
    .tc_o     (tc_o),
    .tag_o    (tag_o),
    .psign_o  (psign_o),
    .sm_o     (sm_o),
    .oc_o     (oc_o),
    .ovf_o    (ovf_o)
);

// File: tb/sd_reverse_conv_bench.sv
module sd_reverse_conv_bench;

    localparam int N    = 6;
    localparam int SPAN = 1 << N;
    localparam int HALF = 1 << (N - 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   sd_pos_i = '0;
    logic [N-1:0]   sd_neg_i = '0;
    logic [N-1:0]   tc_o;
    logic [N-1:0]   tag_o;
    logic [2*N-1:0] psign_o;
    logic [N-1:0]   sm_o;
    logic [N-1:0]   oc_o;
    logic           ovf_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sd_reverse_conv #(.N(N)) u_sd_reverse_conv (
        .clk      (clk),
        .rst_n    (rst_n),
        .sd_pos_i (sd_pos_i),
        .sd_neg_i (sd_neg_i),
        .tc_o     (tc_o),
        .tag_o    (tag_o),
        .psign_o  (psign_o),
        .sm_o     (sm_o),
        .oc_o     (oc_o),
        .ovf_o    (ovf_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (plus=%b minus=%b)",
                     req, act, exp, sd_pos_i, sd_neg_i);
        end
    endtask

    // Apply one operand and compare every output with values computed here
    task automatic apply(input int p, input int m);
        int v, tcx, sv, e_sm, e_oc, e_tag, e_ps, cur;
        bit run, e_ovf;
        @(negedge clk);
        sd_pos_i = p[N-1:0];
        sd_neg_i = m[N-1:0];
        v    = p - m;
        tcx  = ((v % SPAN) + SPAN) % SPAN;
        sv   = (tcx >= HALF) ? tcx - SPAN : tcx;
        e_ovf = (tcx == HALF);
        e_sm = (sv >= 0) ? sv : (HALF | (-sv));
        e_oc = (sv >= 0) ? sv : (HALF | (~(-sv) & (HALF - 1)));
        run = 1'b0;
        cur = 0;
        e_tag = 0;
        e_ps = 0;
        for (int i = 0; i < N; i++) begin
            bit pb, mb;
            pb = p[i];
            mb = m[i];
            if (pb != mb) begin
                run = 1'b1;
                cur = mb ? 3 : 1;
            end
            e_tag = e_tag | (int'(run) << i);
            e_ps  = e_ps | (cur << (2 * i));
        end
        @(negedge clk);
        check("R1 R2 tc", tc_o, tcx);
        check("R3 R2 tag", tag_o, e_tag);
        check("R4 psign", psign_o, e_ps);
        check("R5 tag vs tc", tag_o, e_tag);
        check("R7 ovf", ovf_o, e_ovf);
        if (!e_ovf) begin
            check("R6 sm", sm_o, e_sm);
            check("R8 oc", oc_o, e_oc);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stimulus
        sd_pos_i = 6'b101101;
        sd_neg_i = 6'b010010;
        repeat (3) @(negedge clk);
        // R9: outputs held at zero during reset despite a live operand
        check("R9 tc", tc_o, 0);
        check("R9 tag", tag_o, 0);
        check("R9 psign", psign_o, 0);
        check("R9 sm", sm_o, 0);
        check("R9 oc", oc_o, 0);
        check("R9 ovf", ovf_o, 0);
        rst_n = 1'b1;

        // R10: all-zero operand
        apply(0, 0);
        check("R10 zero tc", tc_o, 0);
        check("R10 zero tag", tag_o, 0);
        check("R10 zero sm", sm_o, 0);

        // R6: worked value 110011 (-13)
        apply(0, 13);
        check("R6 example tag", tag_o, 6'b111111);
        check("R6 example sm", sm_o, 6'b101101);

        // R7: operand landing on the overflow code
        apply(0, HALF);
        check("R7 min ovf", ovf_o, 1);

        // R2: illegal pairs cancel, +1 -1 prefix is nonzero
        apply(6'b000011, 6'b000011);
        check("R2 illegal as zero tag", tag_o, 0);
        apply(6'b000010, 6'b000001);
        check("R4 cancel prefix psign", psign_o[3:0], 4'b0111);

        // Exhaustive sweep of every plus/minus combination
        for (int p = 0; p < SPAN; p++) begin
            for (int m = 0; m < SPAN; m++) begin
                apply(p, m);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule